// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a 32-bit down-counter with a register bus. Software programs a start value, a prescaler and a mode, then enables the timer. An external clock-enable strobe (`tick_en`) drives the count. The prescaler divides that strobe, so the counter steps down once for every P+1 strobes.

When the count runs out, a sticky status flag is set and the interrupt line goes high. The counter then either refills from the load register and keeps going, or it stops at zero. Software clears the flag by writing a 1 to it.

Register offsets on the bus are fixed:

| Offset | Register |
|--------|----------|
| 0x0 | Load value |
| 0x4 | Live counter |
| 0x8 | Control |
| 0xC | Status |

Every access is a full 32-bit word. Writes commit on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`.

Top module: `cdt_timer`

## Requirements
- R1: After reset, load, counter, control and status are all zero, every register reads 0, and `irq` is low.
- R2: Only the four register offsets are mapped. Any other word address reads 0, and a write to it changes no register.
- R3: In the control word, bit 0 is the run enable, bit 1 selects refill on expiry, and bits 15:8 hold the prescaler P. Reading control returns those fields with every other bit 0.
- R4: The counter decrements by one on every (P+1)-th `tick_en` strobe, but only while enabled and nonzero. Without strobes, or while disabled, it holds its value.
- R5: When a decrement takes the counter from 1 to 0, the status flag is set. With refill off, the counter then stays at 0.
- R6: With refill on, expiry sets the status flag and reloads the counter from the load register in the same cycle, and counting continues.
- R7: Writing offset 0x0 sets both the load register and the counter. Writing offset 0x4 changes only the counter.
- R8: When a control write turns enable from 0 to 1, the counter is zero, and the new refill bit is 1, the counter is loaded from the load register.
- R9: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag as it is.
- R10: `irq` equals the status flag at all times.
- R11: Reading offset 0x4 returns 0 while the timer is disabled. The held count is unaffected and reappears on re-enable.
- R12: A counter write, a load write or an enable rise restarts the prescaler. The first decrement after it therefore comes exactly P+1 strobes later.
- R13: A timer that is enabled with a zero count and refill off neither decrements nor sets the status flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe, one prescaler step per cycle it is high |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt, the status flag |

## Verification
A register write takes effect at the clock edge that samples it, so a read issued in the following cycle already shows the new value. Read data has no latency: the bench drives the address one time unit after an edge and samples `bus_rdata` one unit later.

A decrement lands on the edge of the strobe that completes a prescaler period. The bench holds `tick_en` high for an exact number of edges and then checks the counter. It predicts the count from the number of strobes since the last restart point, which is a counter write, a load write or an enable rise. An expiry raises the status flag and `irq` on that same edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned PRE_W    = 8;
    localparam int unsigned EN_BIT   = 0;
    localparam int unsigned RLD_BIT  = 1;
    localparam int unsigned PRE_LSB  = 8;
    localparam int unsigned STAT_BIT = 0;

    localparam int unsigned OFS_LOAD  = 'h0;
    localparam int unsigned OFS_COUNT = 'h4;
    localparam int unsigned OFS_CTRL  = 'h8;
    localparam int unsigned OFS_STAT  = 'hC;

    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] count;
        logic              en;
        logic              autold;
        logic [PRE_W-1:0]  presc;
        logic              status;
    } cdt_state_t;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic             dec_o
);
    logic [PRE_W-1:0] div_d, div_q;
    logic             wrap;

    always_comb begin
        wrap  = (div_q >= presc_i);
        dec_o = run_i && tick_i && !restart_i && wrap;
        div_d = div_q;
        if (restart_i || !run_i) begin
            div_d = '0;
        end else if (tick_i) begin
            div_d = wrap ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // a step is only ever produced on a strobe
    assert_dec_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o |-> (tick_i && run_i));
    // a restart never coincides with a step
    assert_no_dec_on_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |-> !dec_o);
endmodule

// File: rtl/cdt_readmux.sv
module cdt_readmux
    import cdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] load_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              en_i,
    input  logic              autold_i,
    input  logic [PRE_W-1:0]  presc_i,
    input  logic              status_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] ctrl_w;
    logic [DATA_W-1:0] stat_w;

    always_comb begin
        ctrl_w                   = '0;
        ctrl_w[EN_BIT]           = en_i;
        ctrl_w[RLD_BIT]          = autold_i;
        ctrl_w[PRE_LSB +: PRE_W] = presc_i;
        stat_w                   = '0;
        stat_w[STAT_BIT]         = status_i;
        rdata_o                  = '0;
        if (addr_i == ADDR_W'(OFS_LOAD))  rdata_o = load_i;
        if (addr_i == ADDR_W'(OFS_COUNT)) rdata_o = en_i ? count_i : '0;
        if (addr_i == ADDR_W'(OFS_CTRL))  rdata_o = ctrl_w;
        if (addr_i == ADDR_W'(OFS_STAT))  rdata_o = stat_w;
    end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    cdt_state_t s_d, s_q;

    logic wr, wr_load, wr_cnt, wr_ctrl, wr_stat;
    logic en_rise, restart, run, dec, terminal, mapped;

    always_comb begin
        wr       = bus_sel && bus_wr;
        wr_load  = wr && (bus_addr == ADDR_W'(OFS_LOAD));
        wr_cnt   = wr && (bus_addr == ADDR_W'(OFS_COUNT));
        wr_ctrl  = wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_stat  = wr && (bus_addr == ADDR_W'(OFS_STAT));
        mapped   = (bus_addr == ADDR_W'(OFS_LOAD)) || (bus_addr == ADDR_W'(OFS_COUNT)) ||
                   (bus_addr == ADDR_W'(OFS_CTRL)) || (bus_addr == ADDR_W'(OFS_STAT));
        en_rise  = wr_ctrl && !s_q.en && bus_wdata[EN_BIT];
        restart  = wr_load || wr_cnt || en_rise;
        run      = s_q.en && (s_q.count != '0);
        terminal = dec && (s_q.count == DATA_W'(1));

        s_d = s_q;
        if (dec) begin
            if (terminal) s_d.count = s_q.autold ? s_q.load : '0;
            else          s_d.count = s_q.count - 1'b1;
        end
        if (wr_stat && bus_wdata[STAT_BIT]) s_d.status = 1'b0;
        if (terminal)                       s_d.status = 1'b1;
        if (wr_load) begin
            s_d.load  = bus_wdata;
            s_d.count = bus_wdata;
        end
        if (wr_cnt) s_d.count = bus_wdata;
        if (wr_ctrl) begin
            s_d.en     = bus_wdata[EN_BIT];
            s_d.autold = bus_wdata[RLD_BIT];
            s_d.presc  = bus_wdata[PRE_LSB +: PRE_W];
            if (en_rise && (s_q.count == '0) && bus_wdata[RLD_BIT]) s_d.count = s_q.load;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    cdt_prescale i_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_i    (tick_en),
        .restart_i (restart),
        .presc_i   (s_q.presc),
        .dec_o     (dec)
    );

    cdt_readmux #(.ADDR_W(ADDR_W)) i_readmux (
        .addr_i   (bus_addr),
        .load_i   (s_q.load),
        .count_i  (s_q.count),
        .en_i     (s_q.en),
        .autold_i (s_q.autold),
        .presc_i  (s_q.presc),
        .status_i (s_q.status),
        .rdata_o  (bus_rdata)
    );

    assign irq = s_q.status;

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));
    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.en && !wr_load && !wr_cnt && !wr_ctrl) |=> $stable(s_q.count));
    assert_expiry_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        terminal |=> s_q.status);
    assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (terminal && !s_q.autold && !wr_load && !wr_cnt) |=> (s_q.count == '0));
    assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (terminal && s_q.autold && !wr_load && !wr_cnt) |=> (s_q.count == $past(s_q.load)));
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.status && !wr_stat) |=> s_q.status);
    assert_irq_matches_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_STAT)) |-> (bus_rdata[STAT_BIT] == irq));
    assert_count_read_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == ADDR_W'(OFS_COUNT)) && !s_q.en) |-> (bus_rdata == '0));
    assert_idle_at_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == '0 && !s_q.autold && !wr && s_q.en) |=> (s_q.count == '0 && $stable(s_q.status)));
endmodule

// File: tb/test_cdt_timer.sv
module test_cdt_timer;
    localparam int unsigned ADDR_W = 6;
    localparam int NV = 61;
    // vector: {op[1:0], addr[7:0], data[31:0], expect[31:0], req[7:0]}
    // op 0 = write, 1 = read and compare, 2 = hold tick_en high for data edges
    localparam logic [81:0] VEC [NV] = '{
        {2'd1, 8'h00, 32'd0, 32'd0, 8'd1},            // R1 reset values
        {2'd1, 8'h08, 32'd0, 32'd0, 8'd1},
        {2'd1, 8'h0C, 32'd0, 32'd0, 8'd1},
        {2'd1, 8'h04, 32'd0, 32'd0, 8'd1},
        {2'd0, 8'h00, 32'd5, 32'd0, 8'd7},            // R7 load write
        {2'd1, 8'h00, 32'd0, 32'd5, 8'd7},
        {2'd1, 8'h04, 32'd0, 32'd0, 8'd11},           // R11 disabled reads 0
        {2'd0, 8'h08, 32'h1, 32'd0, 8'd3},            // enable, P=0
        {2'd1, 8'h04, 32'd0, 32'd5, 8'd7},            // R7 counter got load
        {2'd2, 8'h00, 32'd2, 32'd0, 8'd4},
        {2'd1, 8'h04, 32'd0, 32'd3, 8'd4},            // R4
        {2'd0, 8'h04, 32'd2, 32'd0, 8'd7},
        {2'd1, 8'h00, 32'd0, 32'd5, 8'd7},            // R7 load untouched
        {2'd1, 8'h04, 32'd0, 32'd2, 8'd7},
        {2'd2, 8'h00, 32'd2, 32'd0, 8'd5},
        {2'd1, 8'h04, 32'd0, 32'd0, 8'd5},            // R5 stops at zero
        {2'd1, 8'h0C, 32'd0, 32'd1, 8'd5},
        {2'd2, 8'h00, 32'd3, 32'd0, 8'd5},
        {2'd1, 8'h04, 32'd0, 32'd0, 8'd5},
        {2'd0, 8'h0C, 32'd0, 32'd0, 8'd9},            // R9 write 0 no effect
        {2'd1, 8'h0C, 32'd0, 32'd1, 8'd9},
        {2'd0, 8'h0C, 32'd1, 32'd0, 8'd9},
        {2'd1, 8'h0C, 32'd0, 32'd0, 8'd9},
        {2'd0, 8'h10, 32'hFFFF, 32'd0, 8'd2},         // R2 unmapped write
        {2'd1, 8'h10, 32'd0, 32'd0, 8'd2},
        {2'd1, 8'h00, 32'd0, 32'd5, 8'd2},
        {2'd1, 8'h08, 32'd0, 32'd1, 8'd2},
        {2'd0, 8'h08, 32'hFFFFFFFF, 32'd0, 8'd3},     // R3 field readback
        {2'd1, 8'h08, 32'd0, 32'h0000FF03, 8'd3},
        {2'd0, 8'h08, 32'h0, 32'd0, 8'd3},
        {2'd0, 8'h08, 32'h3, 32'd0, 8'd8},            // R8 rise at zero with refill
        {2'd1, 8'h04, 32'd0, 32'd5, 8'd8},
        {2'd2, 8'h00, 32'd5, 32'd0, 8'd6},
        {2'd1, 8'h04, 32'd0, 32'd5, 8'd6},            // R6 refilled
        {2'd1, 8'h0C, 32'd0, 32'd1, 8'd6},
        {2'd2, 8'h00, 32'd2, 32'd0, 8'd6},
        {2'd1, 8'h04, 32'd0, 32'd3, 8'd6},
        {2'd0, 8'h0C, 32'd1, 32'd0, 8'd9},
        {2'd0, 8'h08, 32'h0, 32'd0, 8'd4},
        {2'd0, 8'h08, 32'h201, 32'd0, 8'd4},          // R4 P=2
        {2'd2, 8'h00, 32'd2, 32'd0, 8'd4},
        {2'd1, 8'h04, 32'd0, 32'd3, 8'd4},
        {2'd2, 8'h00, 32'd1, 32'd0, 8'd4},
        {2'd1, 8'h04, 32'd0, 32'd2, 8'd4},
        {2'd2, 8'h00, 32'd5, 32'd0, 8'd4},
        {2'd1, 8'h04, 32'd0, 32'd1, 8'd4},
        {2'd0, 8'h04, 32'd4, 32'd0, 8'd12},           // R12 restart on write
        {2'd2, 8'h00, 32'd2, 32'd0, 8'd12},
        {2'd1, 8'h04, 32'd0, 32'd4, 8'd12},
        {2'd2, 8'h00, 32'd1, 32'd0, 8'd12},
        {2'd1, 8'h04, 32'd0, 32'd3, 8'd12},
        {2'd0, 8'h08, 32'h200, 32'd0, 8'd11},         // R11 disable
        {2'd1, 8'h04, 32'd0, 32'd0, 8'd11},
        {2'd2, 8'h00, 32'd6, 32'd0, 8'd11},
        {2'd0, 8'h08, 32'h201, 32'd0, 8'd11},
        {2'd1, 8'h04, 32'd0, 32'd3, 8'd11},
        {2'd0, 8'h04, 32'd0, 32'd0, 8'd13},           // R13 enabled at zero
        {2'd2, 8'h00, 32'd6, 32'd0, 8'd13},
        {2'd1, 8'h0C, 32'd0, 32'd0, 8'd13},
        {2'd1, 8'h04, 32'd0, 32'd0, 8'd13},
        {2'd1, 8'h1C, 32'd0, 32'd0, 8'd2}             // R2 unmapped read
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cdt_timer #(.ADDR_W(ADDR_W)) i_cdt_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[ADDR_W-1:0];
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [7:0]  a, rq;
            logic [31:0] d, e;
            {op, a, d, e, rq} = VEC[i];
            case (op)
                2'd0: bus_write(a, d);
                2'd1: begin
                    bus_read(a, rd);
                    chk($sformatf("R%0d vector %0d", rq, i), rd, e);
                end
                default: ticks(int'(d));
            endcase
        end

        // R10: irq follows status through set and clear
        bus_write(8'h08, 32'h0);
        bus_write(8'h04, 32'd1);
        bus_write(8'h08, 32'h1);
        chk("R10 irq low before expiry", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R10 irq after expiry", {31'd0, irq}, 32'd1);
        bus_write(8'h0C, 32'h1);
        chk("R10 irq after clear", {31'd0, irq}, 32'd0);

        // R1: reset in the middle of a run
        bus_write(8'h00, 32'd9);
        bus_write(8'h08, 32'h3);
        tick_en = 1'b1;
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1; tick_en = 1'b0;
        bus_read(8'h00, rd); chk("R1 load after reset", rd, 32'd0);
        bus_read(8'h08, rd); chk("R1 control after reset", rd, 32'd0);
        bus_read(8'h0C, rd); chk("R1 status after reset", rd, 32'd0);
        bus_write(8'h08, 32'h1);
        bus_read(8'h04, rd); chk("R1 counter after reset", rd, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        done = 1'b1;
        finish_run();
    end
endmodule